// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a 12-bit voltage-output converter. A host sends it commands over three wires: an active-low chip select, a serial clock and a serial data line. While chip select is low, the block shifts in one bit on every rising serial-clock edge. A complete frame has 16 bits. The first three bits are a control code, sent most significant first. The next twelve bits are the data word, also most significant first. The last bit is a sub-bit, which the host should send as zero.

Nothing changes while the frame is being shifted in. When chip select returns high, the block checks the frame. If exactly 16 bits arrived, it decodes the control code. The result can load the input register, copy the input register into the DAC register, load both registers, or enter or leave shutdown. A frame with any other bit count is thrown away.

The three serial inputs come from a slower host domain. Each one passes through a two-stage synchroniser into the system clock domain, and edges are detected there. This requires the system clock to run at least four times faster than the serial clock.

Top module: `dac_cmd_rx`

## Requirements
- R1: After reset, the DAC register and the input register both read zero and the shutdown flag reads 0.
- R2: A 16-bit frame with control code 3'b001 loads its 12 data bits into the input register. The DAC register and the shutdown flag do not change.
- R3: A 16-bit frame with control code 3'b010 copies the current input register into the DAC register. The input register and the shutdown flag do not change, and the frame's data bits are not used.
- R4: A 16-bit frame with control code 3'b011 loads its 12 data bits into both the input register and the DAC register. The shutdown flag does not change.
- R5: A 16-bit frame with control code 3'b100 sets the shutdown flag to 1. Control code 3'b101 clears it to 0. Neither code changes either register.
- R6: A 16-bit frame with control code 3'b000, 3'b110 or 3'b111 changes no output.
- R7: If chip select rises after any bit count other than 16 (fewer or more), the frame is discarded and no output changes.
- R8: The last bit of the frame (the sub-bit) does not affect the result. A frame with a sub-bit of 1 acts exactly like the same frame with a sub-bit of 0.
- R9: While chip select is high, activity on the serial clock and data lines changes no output. It also does not disturb the next frame.
- R10: Outputs change only in response to a rising edge of chip select. While a frame is being shifted in, every output holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_code | output | 12 | DAC register value |
| inreg_code | output | 12 | Input register value |
| shdn | output | 1 | Shutdown status, 1 = shut down |

## Verification
Each rising edge of chip select reaches the registers three system clocks later: two synchroniser stages, then one register stage. The bench waits eight system clocks after raising chip select before it compares the outputs with its own model. Each serial-clock half period lasts four system clocks, and the data line changes a full half period before the serial clock rises, so every bit is stable when the synchronised edge samples it. Before chip select rises, the bench also samples the outputs once a whole frame is in, and expects them to still hold their previous values.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int CTRL_W = 3;
  localparam int DATA_W = 12;
  localparam int SUB_W  = 1;
  localparam int PAY_W  = CTRL_W + DATA_W;
  localparam int FRAME_W = PAY_W + SUB_W;

  typedef enum logic [CTRL_W-1:0] {
    OP_NOP0    = 3'b000,
    OP_LD_IN   = 3'b001,
    OP_CP_DAC  = 3'b010,
    OP_LD_BOTH = 3'b011,
    OP_SD_ON   = 3'b100,
    OP_SD_OFF  = 3'b101
  } dac_op_e;

  typedef struct packed {
    logic wr_in;
    logic wr_dac_data;
    logic cp_dac;
    logic sd_on;
    logic sd_off;
  } dac_act_t;

  function automatic dac_act_t decode_ctrl(input logic [CTRL_W-1:0] c);
    dac_act_t a;
    a = '0;
    case (c)
      OP_LD_IN:   a.wr_in = 1'b1;
      OP_CP_DAC:  a.cp_dac = 1'b1;
      OP_LD_BOTH: begin a.wr_in = 1'b1; a.wr_dac_data = 1'b1; end
      OP_SD_ON:   a.sd_on = 1'b1;
      OP_SD_OFF:  a.sd_off = 1'b1;
      default:    a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [CTRL_W-1:0] pay_ctrl(input logic [PAY_W-1:0] w);
    return w[PAY_W-1 -: CTRL_W];
  endfunction

  function automatic logic [DATA_W-1:0] pay_data(input logic [PAY_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/dac_sync_pipe.sv
module dac_sync_pipe #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift
  import dac_cmd_pkg::*;
#(
  parameter int P_BITS = PAY_W,
  parameter int F_BITS = FRAME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdin_s,
  output logic [P_BITS-1:0] payload,
  output logic              cs_rise,
  output logic              frame_full
);
  localparam int CNT_W = $clog2(F_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(F_BITS);
  localparam logic [CNT_W-1:0] CNT_PAY  = CNT_W'(P_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(F_BITS + 1);

  logic             sclk_d, csn_d;
  logic             sclk_rise;
  logic [CNT_W-1:0] cnt;

  assign sclk_rise  = sclk_s & ~sclk_d & ~csn_s;
  assign cs_rise    = csn_s & ~csn_d;
  assign frame_full = (cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt <= '0;
    else if (csn_s)                         cnt <= '0;
    else if (sclk_rise && cnt != CNT_OVER)  cnt <= cnt + 1'b1;
  end

  // The sub-bit is never stored: shifting stops once the payload is full.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         payload <= '0;
    else if (sclk_rise && cnt < CNT_PAY) payload <= {payload[P_BITS-2:0], sdin_s};
  end
endmodule

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] inreg_code,
  output logic              shdn
);
  dac_act_t act;
  assign act = decode_ctrl(ctrl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code   <= '0;
      inreg_code <= '0;
      shdn       <= 1'b0;
    end else if (commit) begin
      if (act.wr_in)       inreg_code <= data;
      if (act.wr_dac_data) dac_code   <= data;
      else if (act.cp_dac) dac_code   <= inreg_code;
      if (act.sd_on)       shdn <= 1'b1;
      else if (act.sd_off) shdn <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
  import dac_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] inreg_code,
  output logic              shdn
);
  logic [2:0]        raw_in, syn_in;
  logic [PAY_W-1:0]  payload;
  logic              cs_rise, frame_full, commit;
  logic [CTRL_W-1:0] frm_ctrl;
  logic [DATA_W-1:0] frm_data;

  assign raw_in = {sdin, cs_n, sclk};

  dac_sync_pipe #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_in), .q_sync(syn_in)
  );

  dac_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(syn_in[0]), .csn_s(syn_in[1]), .sdin_s(syn_in[2]),
    .payload(payload), .cs_rise(cs_rise), .frame_full(frame_full)
  );

  assign commit   = cs_rise & frame_full;
  assign frm_ctrl = pay_ctrl(payload);
  assign frm_data = pay_data(payload);

  dac_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .ctrl(frm_ctrl), .data(frm_data),
    .dac_code(dac_code), .inreg_code(inreg_code), .shdn(shdn)
  );
endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        commit,
  input logic        cs_rise,
  input logic [2:0]  ctrl,
  input logic [11:0] data,
  input logic [11:0] dac_code,
  input logic [11:0] inreg_code,
  input logic        shdn
);
  AST_HOLD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(dac_code) && $stable(inreg_code) && $stable(shdn)); // R10

  AST_SHORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !commit |=> $stable(dac_code) && $stable(inreg_code) && $stable(shdn)); // R7

  AST_LOAD_IN: assert property (@(posedge clk) disable iff (!rst_n)
    commit && ctrl == 3'b001 |=> inreg_code == $past(data) && $stable(dac_code) && $stable(shdn)); // R2

  AST_COPY_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    commit && ctrl == 3'b010 |=> dac_code == $past(inreg_code) && $stable(inreg_code) && $stable(shdn)); // R3

  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    commit && ctrl == 3'b011 |=> dac_code == $past(data) && inreg_code == $past(data) && $stable(shdn)); // R4

  AST_SHDN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    commit && ctrl == 3'b100 |=> shdn && $stable(dac_code) && $stable(inreg_code)); // R5

  AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    commit && ctrl == 3'b101 |=> !shdn && $stable(dac_code) && $stable(inreg_code)); // R5

  AST_NOP_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (ctrl == 3'b000 || ctrl == 3'b110 || ctrl == 3'b111)
    |=> $stable(dac_code) && $stable(inreg_code) && $stable(shdn)); // R6
endmodule

bind dac_cmd_rx dac_cmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .cs_rise(cs_rise),
  .ctrl(frm_ctrl), .data(frm_data),
  .dac_code(dac_code), .inreg_code(inreg_code), .shdn(shdn)
);

// File: tb/dac_cmd_rx_bench.sv
module dac_cmd_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic [11:0] dac_code, inreg_code;
  logic shdn;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [11:0] m_dac = '0, m_in = '0;
  logic m_sd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_rx u_dac_cmd_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .inreg_code(inreg_code), .shdn(shdn)
  );

  task automatic chk(input string req, input string what, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "dac_code", dac_code, m_dac);
    chk(req, "inreg_code", inreg_code, m_in);
    chk(req, "shdn", {11'd0, shdn}, {11'd0, m_sd});
  endtask

  function automatic string req_of(input logic [2:0] c, input int nb);
    if (nb != 16) return "R7";
    case (c)
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100, 3'b101: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Bench model of a committed frame
  task automatic model_apply(input logic [2:0] c, input logic [11:0] d);
    case (c)
      3'b001: m_in = d;
      3'b010: m_dac = m_in;
      3'b011: begin m_in = d; m_dac = d; end
      3'b100: m_sd = 1'b1;
      3'b101: m_sd = 1'b0;
      default: ;
    endcase
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [2:0] c, input logic [11:0] d, input logic sub,
                            input int nb, input string req);
    logic [15:0] f;
    f = {c, d, sub};
    cs_n = 1'b0;
    wait_clk(HALF_SCLK);
    for (int i = 0; i < nb; i++) begin
      sdin = (i < 16) ? f[15-i] : 1'($urandom % 2);
      wait_clk(HALF_SCLK);
      sclk = 1'b1;
      wait_clk(HALF_SCLK);
      sclk = 1'b0;
    end
    wait_clk(HALF_SCLK);
    chk("R10", "held before chip select rise", dac_code ^ inreg_code ^ {11'd0, shdn},
        m_dac ^ m_in ^ {11'd0, m_sd});
    cs_n = 1'b1;
    wait_clk(8);
    if (nb == 16) model_apply(c, d);
    chk_all(req);
  endtask

  initial begin
    void'($urandom(32'd917));
    wait_clk(3);
    chk_all("R1");
    rst_n = 1'b1;
    wait_clk(3);
    chk_all("R1");

    send_frame(3'b001, 12'hA5C, 1'b0, 16, "R2");
    send_frame(3'b010, 12'h111, 1'b0, 16, "R3");
    send_frame(3'b011, 12'hFFF, 1'b0, 16, "R4");
    send_frame(3'b001, 12'h000, 1'b0, 16, "R2");
    send_frame(3'b100, 12'h123, 1'b0, 16, "R5");
    send_frame(3'b101, 12'h321, 1'b0, 16, "R5");
    send_frame(3'b110, 12'h7FF, 1'b0, 16, "R6");
    send_frame(3'b000, 12'h800, 1'b0, 16, "R6");
    send_frame(3'b111, 12'h001, 1'b0, 16, "R6");
    send_frame(3'b011, 12'h3C3, 1'b0, 15, "R7");
    send_frame(3'b011, 12'h3C3, 1'b0, 17, "R7");
    send_frame(3'b011, 12'h3C3, 1'b0, 0, "R7");
    send_frame(3'b011, 12'h801, 1'b1, 16, "R8");
    send_frame(3'b001, 12'h7FE, 1'b1, 16, "R8");

    // R9: clock and data activity with chip select high
    for (int i = 0; i < 20; i++) begin
      sdin = 1'($urandom % 2);
      wait_clk(2);
      sclk = ~sclk;
    end
    sclk = 1'b0;
    wait_clk(8);
    chk_all("R9");
    send_frame(3'b010, 12'h555, 1'b0, 16, "R9");

    for (int n = 0; n < 60; n++) begin
      logic [2:0] c;
      logic [11:0] d;
      int nb, sel;
      c = 3'($urandom % 8);
      d = 12'($urandom % 4096);
      sel = $urandom % 8;
      nb = (sel == 0) ? 15 : (sel == 1) ? 17 : 16;
      send_frame(c, d, 1'($urandom % 2), nb, req_of(c, nb));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule